// File: doc/BRIEF.md
# Selectable PRBS and Waveform Test-Data Source

This block feeds a link transmitter with one 64-bit test word per accepted transfer. A 3-bit mode select picks one of eight sources. Four are pseudo-random bit sequences of different lengths, and each produces 64 consecutive sequence bits per word. The other four are periodic waveforms: sawtooth, triangle, square and sine. Each waveform word packs four 16-bit two's-complement samples.

An error-insert pulse corrupts exactly one pseudo-random word, so that a downstream checker can be shown to work. The corruption leaves the sequence state untouched. When the mode select changes, the new source restarts from a known point: a fixed all-ones seed for the sequences and phase zero for the waveforms.

The output is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the word and the valid flag hold. A new word is produced only when `en` is high and the output register is empty or being accepted. When `en` is low and the held word is accepted, `out_valid` falls. The generator never advances without a transfer, so no sequence steps are lost under back-pressure. The reset is synchronous and active high.

Top module: `pattern_source`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is cleared. After reset, `out_valid` stays low until `en` is high. Every sequence register is seeded with all ones, and the waveform phase is set to zero.
- R2: `sel` values 0, 1, 2 and 3 select the polynomials x^7+x^6+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. For a register s of degree N with middle tap K, each step computes b = s[N-1] xor s[K-1] and shifts b in at bit 0. Output bit i of a word is the b of the i-th step in that word. The first word after reset or reload starts from the all-ones seed.
- R3: Consecutive words of one sequence mode continue the sequence without gaps or repeats.
- R4: In a sequence mode, an `err_inj` pulse inverts bit 0 of exactly one word. That word is the one emitted in the same cycle if one is emitted, otherwise the next word emitted. Later words are the ones that would follow with no pulse.
- R5: `sel` values 4, 5 and 6 give sawtooth, triangle and square. Lane j (bits 16j+15 down to 16j) carries the sample for phase p = (phase + j) mod 256. Sawtooth is (p-128)*256. Triangle is -32768 + 512*p for p < 128, and -32768 + 512*(255-p) otherwise. Square is +32767 for p < 128 and -32767 otherwise.
- R6: `sel` value 7 gives a sine: round(32767*|sin(2*pi*(p+0.5)/256)|), with the sign of the sine applied.
- R7: The waveform phase advances by 4 on each emitted word and wraps modulo 256.
- R8: A change of `sel` takes effect at the next clock edge. At that edge the new source is reloaded, any held word is dropped, `out_valid` is low for that cycle, and a pending error request is cancelled.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold.
- R10: With `en` low, no new word is produced. When `en` returns high, the sequence resumes exactly where it stopped.
- R11: In waveform modes, `err_inj` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 3 | Source select: 0-3 sequences, 4 saw, 5 triangle, 6 square, 7 sine |
| en | input | 1 | Allows new words to be produced |
| err_inj | input | 1 | One-cycle request to corrupt one sequence word |
| out_ready | input | 1 | Consumer accepts the current word |
| out_data | output | 64 | Test word |
| out_valid | output | 1 | `out_data` holds a word |

## Verification
The hardest case is a corrupted word that must differ from the clean sequence in bit 0 only, followed by words that carry on as though no corruption happened. The stimulus pulses `err_inj` in the middle of a free-running stream. The expected-word model flips only the copy it queues and never alters its own register state. A stall with `out_ready` low is placed in the middle of a sequence. A mode change is made while words are still flowing, to reach the drop-and-reload edge. Each waveform mode runs for more than 64 words, so the phase wraps at least once.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  typedef enum logic [1:0] {
    SH_SAW = 2'd0,
    SH_TRI = 2'd1,
    SH_SQR = 2'd2,
    SH_SIN = 2'd3
  } shape_e;

  // Degree of each selectable sequence polynomial (index = sel[1:0]).
  function automatic int poly_len(input int idx);
    case (idx)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  // Middle feedback tap of each polynomial.
  function automatic int poly_tap(input int idx);
    case (idx)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction

endpackage

// File: rtl/pgen_lfsr.sv
module pgen_lfsr #(
  parameter int N = 7,
  parameter int K = 6,
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] word
);

  logic [N-1:0] st;
  logic [N-1:0] st_nx;
  logic [N-1:0] s;

  // W sequence steps unrolled per clock.
  always_comb begin
    s    = st;
    word = '0;
    for (int i = 0; i < W; i++) begin
      word[i] = s[N-1] ^ s[K-1];
      s       = {s[N-2:0], word[i]};
    end
    st_nx = s;
  end

  always_ff @(posedge clk) begin
    if (rst || load) st <= '1;
    else if (step)   st <= st_nx;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (st != '0)); // R2

endmodule

// File: rtl/pgen_wave.sv
module pgen_wave import pgen_pkg::*; #(
  parameter int DATA_W   = 64,
  parameter int SAMPLE_W = 16,
  parameter int PHASE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  shape_e            shape,
  output logic [DATA_W-1:0] word
);

  localparam int LANES = DATA_W / SAMPLE_W;
  localparam int QN    = 1 << (PHASE_W - 2);
  localparam int ZW    = SAMPLE_W - PHASE_W + 1;
  localparam real PI   = 3.14159265358979;

  function automatic logic [SAMPLE_W-1:0] qsin(input int i);
    real ang;
    real amp;
    ang = PI * (2.0 * real'(i) + 1.0) / (4.0 * real'(QN));
    amp = real'((1 << (SAMPLE_W - 1)) - 1);
    return SAMPLE_W'($rtoi(amp * $sin(ang) + 0.5));
  endfunction

  logic [PHASE_W-1:0]  phase;
  logic [SAMPLE_W-1:0] sin_tab [QN];

  for (genvar i = 0; i < QN; i++) begin : g_tab
    assign sin_tab[i] = qsin(i);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [PHASE_W-1:0]  p;
    logic [PHASE_W-2:0]  t;
    logic [PHASE_W-3:0]  idx;
    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] smp;
    always_comb begin
      p   = phase + PHASE_W'(j);
      t   = p[PHASE_W-1] ? ~p[PHASE_W-2:0] : p[PHASE_W-2:0];
      idx = p[PHASE_W-2] ? ~p[PHASE_W-3:0] : p[PHASE_W-3:0];
      mag = sin_tab[idx];
      case (shape)
        SH_SAW: smp = {~p[PHASE_W-1], p[PHASE_W-2:0], {(SAMPLE_W-PHASE_W){1'b0}}};
        SH_TRI: smp = {~t[PHASE_W-2], t[PHASE_W-3:0], {ZW{1'b0}}};
        SH_SQR: smp = p[PHASE_W-1] ? {1'b1, {(SAMPLE_W-2){1'b0}}, 1'b1}
                                   : {1'b0, {(SAMPLE_W-1){1'b1}}};
        default: smp = p[PHASE_W-1] ? (~mag + 1'b1) : mag;
      endcase
    end
    assign word[j*SAMPLE_W +: SAMPLE_W] = smp;
  end

  always_ff @(posedge clk) begin
    if (rst || load) phase <= '0;
    else if (step)   phase <= phase + PHASE_W'(LANES);
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (phase == $past(phase) + PHASE_W'(LANES))); // R7

  AST_PHASE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (phase == '0)); // R8

endmodule

// File: rtl/pattern_source.sv
module pattern_source import pgen_pkg::*; #(
  parameter int DATA_W   = 64,
  parameter int SAMPLE_W = 16,
  parameter int PHASE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sel,
  input  logic              en,
  input  logic              err_inj,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  localparam int NPOLY = 4;

  logic [2:0]        mode_q;
  logic              changed;
  logic              adv;
  logic              is_wave;
  logic              err_pend;
  logic              flip;
  logic [DATA_W-1:0] prbs_w [NPOLY];
  logic [DATA_W-1:0] wave_w;
  logic [DATA_W-1:0] word;

  assign changed = (sel != mode_q);
  assign is_wave = mode_q[2];
  assign adv     = en && !changed && (!out_valid || out_ready);
  assign flip    = !is_wave && (err_pend || err_inj);

  for (genvar g = 0; g < NPOLY; g++) begin : g_poly
    pgen_lfsr #(
      .N(poly_len(g)),
      .K(poly_tap(g)),
      .W(DATA_W)
    ) u_lfsr (
      .clk  (clk),
      .rst  (rst),
      .load (changed),
      .step (adv && !is_wave && (mode_q[1:0] == 2'(g))),
      .word (prbs_w[g])
    );
  end

  pgen_wave #(
    .DATA_W  (DATA_W),
    .SAMPLE_W(SAMPLE_W),
    .PHASE_W (PHASE_W)
  ) u_wave (
    .clk  (clk),
    .rst  (rst),
    .load (changed),
    .step (adv && is_wave),
    .shape(shape_e'(mode_q[1:0])),
    .word (wave_w)
  );

  assign word = is_wave ? wave_w : prbs_w[mode_q[1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= sel;
      out_valid <= 1'b0;
      out_data  <= '0;
      err_pend  <= 1'b0;
    end else if (changed) begin
      mode_q    <= sel;
      out_valid <= 1'b0;
      err_pend  <= 1'b0;
    end else begin
      if (adv) begin
        out_data  <= word ^ DATA_W'(flip);
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (adv && !is_wave)          err_pend <= 1'b0;
      else if (err_inj && !is_wave) err_pend <= 1'b1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && sel == mode_q) |=> (out_valid && $stable(out_data))); // R9

  AST_RELOAD_DROP: assert property (@(posedge clk) disable iff (rst)
    (sel != mode_q) |=> !out_valid); // R8

  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(en)); // R10

endmodule

// File: tb/sim_pattern_source.sv
module sim_pattern_source;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  sel = 3'd0;
  logic        en = 1'b0;
  logic        err_inj = 1'b0;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] exp_q [$];
  string       tag_q [$];

  logic [31:0] m_st;
  int          m_phase;
  int          m_mode;

  always #10 clk = ~clk;

  pattern_source u0 (
    .clk(clk), .rst(rst), .sel(sel), .en(en), .err_inj(err_inj),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int tap_n(input int m);
    case (m) 0: return 7; 1: return 15; 2: return 23; default: return 31; endcase
  endfunction
  function automatic int tap_k(input int m);
    case (m) 0: return 6; 1: return 14; 2: return 18; default: return 28; endcase
  endfunction

  function automatic logic [15:0] wsamp(input int shp, input int p);
    real s;
    int  mag;
    case (shp)
      0: return 16'((p - 128) * 256);
      1: return (p < 128) ? 16'(-32768 + 512 * p) : 16'(-32768 + 512 * (255 - p));
      2: return (p < 128) ? 16'h7FFF : 16'h8001;
      default: begin
        s   = $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 256.0);
        mag = $rtoi(32767.0 * ((s < 0.0) ? -s : s) + 0.5);
        return (s < 0.0) ? 16'(-mag) : 16'(mag);
      end
    endcase
  endfunction

  function automatic logic [63:0] model_next();
    logic [63:0] w;
    int n, k;
    logic b;
    w = '0;
    if (m_mode < 4) begin
      n = tap_n(m_mode);
      k = tap_k(m_mode);
      for (int i = 0; i < 64; i++) begin
        b    = m_st[n-1] ^ m_st[k-1];
        w[i] = b;
        m_st = ((m_st << 1) | 32'(b)) & ((32'd1 << n) - 32'd1);
      end
    end else begin
      for (int j = 0; j < 4; j++) w[16*j +: 16] = wsamp(m_mode - 4, (m_phase + j) % 256);
      m_phase = (m_phase + 4) % 256;
    end
    return w;
  endfunction

  // Driver: one cycle with en and ready high; queue the word it produces.
  task automatic step_push(input bit err, input string tag);
    logic [63:0] w;
    w = model_next();
    if (err && m_mode < 4) w[0] = ~w[0];
    exp_q.push_back(w);
    tag_q.push_back(tag);
    en = 1'b1; out_ready = 1'b1; err_inj = err;
    @(negedge clk);
    err_inj = 1'b0;
  endtask

  task automatic change_mode(input int m);
    sel = 3'(m); err_inj = 1'b0;
    m_mode = m; m_st = 32'hFFFF_FFFF; m_phase = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid after select change", 64'(out_valid), 64'd0);
  endtask

  task automatic stall(input int n);
    logic [63:0] held;
    out_ready = 1'b0; en = 1'b1;
    @(negedge clk);
    held = out_data;
    check(out_valid == 1'b1, "R9 valid at stall start", 64'(out_valid), 64'd1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1 && out_data == held, "R9 hold under stall", out_data, held);
    end
  endtask

  task automatic idle(input int n);
    en = 1'b0; out_ready = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    check(out_valid == 1'b0, "R10 no word while disabled", 64'(out_valid), 64'd0);
  endtask

  // Monitor: samples just before each rising edge.
  initial begin
    logic [63:0] e;
    string t;
    forever begin
      @(negedge clk);
      #5;
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected word", out_data, 64'd0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data === e, t, out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_mode = 0; m_st = 32'hFFFF_FFFF; m_phase = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid low in reset", 64'(out_valid), 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid low before enable", 64'(out_valid), 64'd0);

    // PRBS7 from seed
    step_push(1'b0, "R2 PRBS7 first word");
    for (int i = 0; i < 39; i++) step_push(1'b0, "R3 PRBS7 continuity");

    // PRBS15, mode change mid-stream, stall inside
    change_mode(1);
    step_push(1'b0, "R2 PRBS15 first word");
    for (int i = 0; i < 15; i++) step_push(1'b0, "R3 PRBS15 continuity");
    stall(4);
    for (int i = 0; i < 20; i++) step_push(1'b0, "R9 PRBS15 after stall");

    // PRBS23 with one injected error
    change_mode(2);
    step_push(1'b0, "R2 PRBS23 first word");
    for (int i = 0; i < 9; i++) step_push(1'b0, "R3 PRBS23 continuity");
    step_push(1'b1, "R4 PRBS23 flipped word");
    for (int i = 0; i < 20; i++) step_push(1'b0, "R4 PRBS23 after flip");
    idle(3);
    for (int i = 0; i < 10; i++) step_push(1'b0, "R10 PRBS23 resume");

    // PRBS31
    change_mode(3);
    step_push(1'b0, "R2 PRBS31 first word");
    for (int i = 0; i < 39; i++) step_push(1'b0, "R3 PRBS31 continuity");

    // Waveforms, each past one full period
    change_mode(4);
    for (int i = 0; i < 30; i++) step_push(1'b0, "R5 sawtooth");
    step_push(1'b1, "R11 sawtooth with error request");
    for (int i = 0; i < 40; i++) step_push(1'b0, "R7 sawtooth wrap");
    change_mode(5);
    for (int i = 0; i < 70; i++) step_push(1'b0, "R5 triangle");
    change_mode(6);
    for (int i = 0; i < 70; i++) step_push(1'b0, "R5 square");
    change_mode(7);
    for (int i = 0; i < 66; i++) step_push(1'b0, "R6 sine");
    step_push(1'b1, "R11 sine with error request");
    for (int i = 0; i < 4; i++) step_push(1'b0, "R7 sine wrap");

    idle(4);
    check(exp_q.size() == 0, "R3 all queued words seen", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule